// File: doc/BRIEF.md
# Asynchronous Parallel ROM Read Controller

This block connects a clocked host to an asynchronous parallel read-only memory and performs one read at a time. The host presents a byte address together with a width flag on a valid/ready request channel. The controller latches the request and drives the memory's address lines, select and read-enable strobes and its width-select pin. It waits a fixed number of clock cycles so that every access interval has expired, samples the data bus and returns the result with a one-cycle response strobe.

All memory timings are given in nanoseconds and converted to whole clock cycles, rounded up, from a clock-period parameter. The wait before sampling covers the longest of three intervals: address-to-data, select-to-data and read-enable-to-data. A recovery phase after each access does two things. It lets the memory's outputs float before anything else may drive the shared pin, and it keeps successive accesses at least one read cycle apart.

In 8-bit mode the memory reuses its top data pin as the lowest address input. The controller drives bit 0 of the request address onto that pin and returns only the low data lane. In 16-bit mode it leaves the pin undriven and returns the full word.

Top module: `rom_rd_ctrl`

## Requirements
- R1: After reset, `req_ready_o`=1, `rom_cs_no`=1, `rom_rd_en_no`=1, `rsp_valid_o`=0, `rom_lsb_drv_o`=0 and `rom_x16_o`=1.
- R2: A request is taken only in a cycle where `req_valid_i` and `req_ready_o` are both 1. `req_ready_o` is 0 from the cycle after acceptance until recovery ends, and it is 0 whenever `rsp_valid_o` is 1.
- R3: `rom_cs_no` falls one cycle before `rom_rd_en_no`. Data is sampled only after three intervals have all expired: ceil(T_AA/CLK) and ceil(T_ACE/CLK) cycles from address and select, and ceil(T_OE/CLK) cycles from read enable.
- R4: For `req_x8_i`=0 (16-bit), `rom_a_o` = `req_addr_i[AW:1]`, `rom_x16_o`=1 and `rom_lsb_drv_o`=0. The response is the full 16-bit memory word, and `req_addr_i[0]` has no effect on the result.
- R5: For `req_x8_i`=1 (8-bit), `rom_a_o` = `req_addr_i[AW:1]` and `rom_x16_o`=0. `rom_lsb_drv_o`=1 and `rom_lsb_o` = `req_addr_i[0]` while the select is active. The response is {8'h00, memory data[7:0]}.
- R6: Each accepted request produces exactly one `rsp_valid_o` pulse, one cycle wide, and the responses come back in request order.
- R7: Successive falling edges of `rom_cs_no` are at least T_RC apart.
- R8: After `rom_rd_en_no` rises, neither strobe falls again for at least T_HZ. The controller never drives the shared pin while the memory may still drive it in 16-bit mode.
- R9: `rom_a_o`, `rom_lsb_o` and `rom_x16_o` stay constant while `rom_cs_no` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller idle, request can be taken |
| req_addr_i | input | AW+1 | Byte address; bit 0 selects the byte in 8-bit mode |
| req_x8_i | input | 1 | 1 = 8-bit read, 0 = 16-bit read |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_data_o | output | DW | Read data, zero-extended in 8-bit mode |
| rom_a_o | output | AW | Memory word address lines |
| rom_cs_no | output | 1 | Memory select, active low |
| rom_rd_en_no | output | 1 | Memory output enable, active low |
| rom_x16_o | output | 1 | Width select, 1 = 16-bit |
| rom_lsb_o | output | 1 | Value for the shared low-address/top-data pin |
| rom_lsb_drv_o | output | 1 | Drive enable for the shared pin |
| rom_q_i | input | DW | Memory data bus |

## Verification
Two things can fall in the same cycle: the response strobe for one read, and a waiting request for the next read that has been held valid since the previous acceptance. The bench keeps `req_valid_i` high across back-to-back reads and switches between widths, so a new request is already pending while the previous response is delivered and during recovery. It then checks three things at the ports. The pending request is taken only once recovery ends. The earlier response carries that earlier read's data. The memory model reports no read-cycle, float or shared-pin contention violation at the boundary between a 16-bit read and an 8-bit read.

// File: rtl/rom_rd_pkg.sv
package rom_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WAIT,
    ST_CAPTURE,
    ST_RECOVER
  } rd_state_e;

  function automatic int cdiv(input int ns, input int period);
    return (ns + period - 1) / period;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rom_rd_timer.sv
module rom_rd_timer #(
  parameter int TW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          done_o
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - TW'(1);
  end

  assign done_o = (cnt_q == '0);

  // R7
  tmr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - TW'(1)));

endmodule

// File: rtl/rom_rd_lane.sv
module rom_rd_lane #(
  parameter int AW = 21,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic [AW:0]   addr_i,
  input  logic          x8_i,
  input  logic          drive_i,
  input  logic          cap_i,
  input  logic [DW-1:0] rom_q_i,
  output logic [AW-1:0] rom_a_o,
  output logic          rom_lsb_o,
  output logic          rom_lsb_drv_o,
  output logic          rom_x16_o,
  output logic [DW-1:0] data_o
);

  localparam int HW = DW / 2;

  logic [DW-1:0] lane_d;

  // narrow reads keep only the low lane
  assign lane_d = rom_x16_o ? rom_q_i : {{(DW-HW){1'b0}}, rom_q_i[HW-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rom_a_o   <= '0;
      rom_lsb_o <= 1'b0;
      rom_x16_o <= 1'b1;
    end else if (take_i) begin
      rom_a_o   <= addr_i[AW:1];
      rom_lsb_o <= x8_i & addr_i[0];
      rom_x16_o <= ~x8_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    data_o <= '0;
    else if (cap_i) data_o <= lane_d;
  end

  assign rom_lsb_drv_o = ~rom_x16_o & drive_i;

  // R9
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_i && $past(drive_i)) |-> ($stable(rom_a_o) && $stable(rom_lsb_o) && $stable(rom_x16_o)));

  // R4
  wide_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |-> (rom_x16_o ? !rom_lsb_drv_o : rom_lsb_drv_o));

endmodule

// File: rtl/rom_rd_ctrl.sv
module rom_rd_ctrl
  import rom_rd_pkg::*;
#(
  parameter int CLK_NS   = 20,
  parameter int T_RC_NS  = 100,
  parameter int T_AA_NS  = 100,
  parameter int T_ACE_NS = 100,
  parameter int T_OE_NS  = 50,
  parameter int T_HZ_NS  = 40,
  parameter int AW       = 21,
  parameter int DW       = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW:0]   req_addr_i,
  input  logic          req_x8_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_data_o,
  output logic [AW-1:0] rom_a_o,
  output logic          rom_cs_no,
  output logic          rom_rd_en_no,
  output logic          rom_x16_o,
  output logic          rom_lsb_o,
  output logic          rom_lsb_drv_o,
  input  logic [DW-1:0] rom_q_i
);

  localparam int C_AA  = cdiv(T_AA_NS, CLK_NS);
  localparam int C_ACE = cdiv(T_ACE_NS, CLK_NS);
  localparam int C_OE  = cdiv(T_OE_NS, CLK_NS);
  localparam int C_RC  = cdiv(T_RC_NS, CLK_NS);
  localparam int C_HZ  = cdiv(T_HZ_NS, CLK_NS);
  // sample edge: 2+W cycles after select, W+1 after read enable
  localparam int W_CYC = imax(1, imax(imax(C_AA, C_ACE) - 2, C_OE - 1));
  // whole cycle SETUP..IDLE is 3+W+R cycles
  localparam int R_CYC = imax(1, imax(C_HZ, C_RC - 3 - W_CYC));
  localparam int TW    = imax(1, $clog2(imax(W_CYC, R_CYC)));

  rd_state_e     state_q;
  logic          take, cap, tmr_load, tmr_done;
  logic [TW-1:0] tmr_val;

  assign req_ready_o = (state_q == ST_IDLE);
  assign take        = req_ready_o & req_valid_i;
  assign cap         = (state_q == ST_CAPTURE);
  assign tmr_load    = (state_q == ST_SETUP) | cap;
  assign tmr_val     = (state_q == ST_SETUP) ? TW'(W_CYC - 1) : TW'(R_CYC - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      rom_cs_no    <= 1'b1;
      rom_rd_en_no <= 1'b1;
      rsp_valid_o  <= 1'b0;
    end else begin
      rsp_valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (take) begin
          state_q   <= ST_SETUP;
          rom_cs_no <= 1'b0;
        end
        ST_SETUP: begin
          state_q      <= ST_WAIT;
          rom_rd_en_no <= 1'b0;
        end
        ST_WAIT: if (tmr_done) state_q <= ST_CAPTURE;
        ST_CAPTURE: begin
          state_q      <= ST_RECOVER;
          rom_cs_no    <= 1'b1;
          rom_rd_en_no <= 1'b1;
          rsp_valid_o  <= 1'b1;
        end
        ST_RECOVER: if (tmr_done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  rom_rd_timer #(.TW(TW)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .done_o (tmr_done)
  );

  rom_rd_lane #(.AW(AW), .DW(DW)) i_lane (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .take_i        (take),
    .addr_i        (req_addr_i),
    .x8_i          (req_x8_i),
    .drive_i       (~rom_cs_no),
    .cap_i         (cap),
    .rom_q_i       (rom_q_i),
    .rom_a_o       (rom_a_o),
    .rom_lsb_o     (rom_lsb_o),
    .rom_lsb_drv_o (rom_lsb_drv_o),
    .rom_x16_o     (rom_x16_o),
    .data_o        (rsp_data_o)
  );

  // R6
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  // R2
  rsp_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o);

  // R3
  en_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rom_rd_en_no) |-> (!rom_cs_no && $past(!rom_cs_no)));

  // R3
  cap_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap |-> (!rom_cs_no && !rom_rd_en_no));

  // R8
  float_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rom_rd_en_no) |-> (rom_cs_no && !req_ready_o));

endmodule

// File: tb/test_rom_rd_ctrl.sv
`timescale 1ns/100ps
module test_rom_rd_ctrl;

  localparam int AW = 21;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b1;
  logic          req_valid = 1'b0;
  logic [AW:0]   req_addr = '0;
  logic          req_x8 = 1'b0;
  logic          req_ready_o, rsp_valid_o;
  logic [DW-1:0] rsp_data_o;
  logic [AW-1:0] rom_a_o;
  logic          rom_cs_no, rom_rd_en_no, rom_x16_o, rom_lsb_o, rom_lsb_drv_o;
  logic [DW-1:0] rom_q = 16'hBAD0;

  int n_chk = 0, n_err = 0, n_req = 0, n_rsp = 0;
  int rc_viol = 0, flt_viol = 0, cont_viol = 0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];
  logic          rsp_prev = 1'b0;

  real t_addr = -1000.0, t_cs = -1000.0, t_oe = -1000.0;
  real t_oer = -1000.0, t_csf = -1000.0;
  logic last_x16 = 1'b1;
  logic seen_cs = 1'b0;

  always #10 clk = ~clk;

  rom_rd_ctrl i_rom_rd_ctrl (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid),
    .req_ready_o   (req_ready_o),
    .req_addr_i    (req_addr),
    .req_x8_i      (req_x8),
    .rsp_valid_o   (rsp_valid_o),
    .rsp_data_o    (rsp_data_o),
    .rom_a_o       (rom_a_o),
    .rom_cs_no     (rom_cs_no),
    .rom_rd_en_no  (rom_rd_en_no),
    .rom_x16_o     (rom_x16_o),
    .rom_lsb_o     (rom_lsb_o),
    .rom_lsb_drv_o (rom_lsb_drv_o),
    .rom_q_i       (rom_q)
  );

  function automatic logic [15:0] rom_word(input logic [AW-1:0] a);
    return a[15:0] ^ {a[20:16], 11'h000} ^ 16'h3C96;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  // memory model: timestamps of pin changes
  always @(rom_a_o or rom_lsb_o or rom_x16_o) t_addr = $realtime;
  always @(negedge rom_rd_en_no) begin
    if ($realtime - t_oer < 39.5) flt_viol++;
    t_oe = $realtime;
  end
  always @(posedge rom_rd_en_no) begin
    t_oer = $realtime;
    last_x16 = rom_x16_o;
  end
  always @(negedge rom_cs_no) begin
    if (seen_cs && ($realtime - t_csf < 99.5)) rc_viol++;
    if ($realtime - t_oer < 39.5) flt_viol++;
    seen_cs = 1'b1;
    t_csf = $realtime;
    t_cs = $realtime;
  end

  initial begin
    #0.25;
    forever begin
      real now;
      logic ok, drv15;
      logic [15:0] w;
      now = $realtime;
      ok = (rom_cs_no === 1'b0) && (rom_rd_en_no === 1'b0) &&
           (now - t_addr >= 99.0) && (now - t_cs >= 99.0) && (now - t_oe >= 49.0);
      w = rom_word(rom_a_o);
      if (!ok)                   rom_q = 16'hBAD0;
      else if (rom_x16_o === 1'b1) rom_q = w;
      else                       rom_q = {8'hEE, (rom_lsb_o ? w[15:8] : w[7:0])};
      drv15 = ((rom_cs_no === 1'b0) && (rom_rd_en_no === 1'b0) && (rom_x16_o === 1'b1)) ||
              (last_x16 && (now - t_oer < 39.5));
      if (drv15 && (rom_lsb_drv_o === 1'b1)) cont_viol++;
      #0.5;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_ni) begin
      if (rsp_valid_o) begin
        n_rsp++;
        check("R6 pulse width", {31'd0, rsp_prev}, 32'd0);
        if (exp_q.size() == 0) begin
          check("R6 unexpected response", 32'd1, 32'd0);
        end else begin
          logic [15:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, {16'd0, rsp_data_o}, {16'd0, e});
        end
      end
      rsp_prev <= rsp_valid_o;
    end
  end

  task automatic do_read(input logic [AW:0] a, input logic x8, input logic hold);
    logic [15:0] w;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    req_x8    = x8;
    while (!req_ready_o) @(negedge clk);
    w = rom_word(a[AW:1]);
    if (x8) begin
      exp_q.push_back({8'h00, (a[0] ? w[15:8] : w[7:0])});
      tag_q.push_back("R5 byte data (R3 timing)");
    end else begin
      exp_q.push_back(w);
      tag_q.push_back("R4 word data (R3 timing)");
    end
    n_req++;
    @(negedge clk);
    check("R2 ready low after accept", {31'd0, req_ready_o}, 32'd0);
    check(x8 ? "R5 address pins" : "R4 address pins", {11'd0, rom_a_o}, {11'd0, a[AW:1]});
    check(x8 ? "R5 width pin" : "R4 width pin", {31'd0, rom_x16_o}, {31'd0, ~x8});
    check(x8 ? "R5 shared pin drive" : "R4 shared pin released", {31'd0, rom_lsb_drv_o}, {31'd0, x8});
    if (x8) check("R5 shared pin value", {31'd0, rom_lsb_o}, {31'd0, a[0]});
    check("R3 select active", {31'd0, rom_cs_no}, 32'd0);
    @(negedge clk);
    check("R9 address held", {11'd0, rom_a_o}, {11'd0, a[AW:1]});
    check("R3 read enable after select", {31'd0, rom_rd_en_no}, 32'd0);
    if (!hold) req_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual expired expected done");
    finish_run();
  end

  initial begin
    #2 rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 ready", {31'd0, req_ready_o}, 32'd1);
    check("R1 select", {31'd0, rom_cs_no}, 32'd1);
    check("R1 read enable", {31'd0, rom_rd_en_no}, 32'd1);
    check("R1 rsp", {31'd0, rsp_valid_o}, 32'd0);
    check("R1 shared pin", {31'd0, rom_lsb_drv_o}, 32'd0);
    check("R1 width", {31'd0, rom_x16_o}, 32'd1);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check("R2 idle ignores no request", {31'd0, rom_cs_no}, 32'd1);

    // R4 word reads, bit 0 ignored
    do_read(22'h000000, 1'b0, 1'b0);
    do_read(22'h000001, 1'b0, 1'b0);
    do_read(22'h3FFFFF, 1'b0, 1'b0);
    do_read(22'h2AAAAA, 1'b0, 1'b0);
    // R5 byte reads, both lanes
    do_read(22'h123456, 1'b1, 1'b0);
    do_read(22'h123457, 1'b1, 1'b0);
    do_read(22'h3FFFFF, 1'b1, 1'b0);
    // back-to-back held requests, mixed widths (R7, R8)
    do_read(22'h0F0F0E, 1'b0, 1'b1);
    do_read(22'h0F0F0F, 1'b1, 1'b1);
    do_read(22'h155554, 1'b0, 1'b1);
    do_read(22'h155555, 1'b1, 1'b1);
    do_read(22'h200001, 1'b1, 1'b1);
    do_read(22'h200000, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++)
      do_read(22'(i * 22'h05A5A3), i[0], i[1]);
    req_valid = 1'b0;

    repeat (20) @(negedge clk);
    check("R6 all responses returned", n_rsp, n_req);
    check("R6 queue empty", exp_q.size(), 0);
    check("R7 read cycle violations", rc_viol, 0);
    check("R8 float violations", flt_viol, 0);
    check("R8 shared pin contention", cont_viol, 0);
    check("R2 idle after run", {31'd0, req_ready_o}, 32'd1);
    finish_run();
  end

endmodule